// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer with Address-Space Tags

This block caches virtual-to-physical page mappings for 4 KB pages in a small fully associative array. Every entry carries an 8-bit address-space tag, so mappings from several processes can coexist. A translation only succeeds when both the virtual page number and the tag match the tag of the running process. A lookup presents a 32-bit virtual address, the current address-space tag, the privilege mode and a load/store flag. One cycle later the block returns exactly one outcome: a 36-bit physical address, a miss, a privilege fault or a write-permission fault. A miss is left to refill software.

Software loads entries through a write port. A write either names a slot directly or uses a replacement slot picked by a free-running countdown. The countdown never drops below a programmable boundary. Slots under that boundary are pinned and are never overwritten by a replacement-slot write.

Top module: `tlb_asid_top`

## Requirements
- R1: Each lookup returns its result on the clock edge after it is presented, with `res_valid` high. On a hit, `res_paddr` is the matched 24-bit frame number followed by the 12 unchanged low address bits.
- R2: A hit needs an entry whose valid bit is set, whose page number equals `lk_vaddr[31:12]` and whose tag equals `lk_asid`. If no entry qualifies and there is no privilege fault, the result is a miss. Every valid result has exactly one of hit, miss, privilege fault or modify fault.
- R3: The region is decoded from `lk_vaddr[31:29]`. If bit 31 is 0 the region is user level, 3'b110 is supervisor level, and 3'b100, 3'b101 and 3'b111 are kernel level. `lk_mode` 2'b00 is user, 2'b01 is supervisor, and 2'b10 or 2'b11 is kernel. A region above the current mode gives a privilege fault, whatever the array holds.
- R4: A store (`lk_store`=1) that matches an entry whose writable bit is clear gives a modify fault and no hit. A load from the same entry hits.
- R5: When two or more entries qualify, the lowest-numbered one supplies the frame and `res_multi_hit` is raised. It is raised only when two or more entries qualify and there is no privilege fault.
- R6: A write with `wr_random`=0 stores the entry at `wr_index` and is visible to lookups from the next cycle on. A `wr_index` of 48 or above writes nothing.
- R7: Reset leaves `rnd_index` at 47. Each cycle it drops by one, and in the cycle after it equals the boundary it returns to 47.
- R8: Asserting `wired_we` loads the boundary from `wired_val`, clamped to 47, and sets `rnd_index` to 47 on the next cycle.
- R9: A write with `wr_random`=1 stores the entry at the slot shown on `rnd_index` in that cycle. Slots below the boundary are never written this way.
- R10: After reset all entries are invalid and every result output is zero.
- R11: In a cycle after `lk_valid` was low, `res_valid`, all flags and `res_paddr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Address-space tag of the running process |
| lk_mode | input | 2 | Privilege mode (00 user, 01 supervisor, 1x kernel) |
| lk_store | input | 1 | 1 for a store access, 0 for a load |
| wr_en | input | 1 | Entry write strobe |
| wr_random | input | 1 | 1 to write at the replacement slot instead of `wr_index` |
| wr_index | input | 6 | Explicit slot number |
| wr_vpn | input | 20 | Virtual page number to store |
| wr_asid | input | 8 | Address-space tag to store |
| wr_pfn | input | 24 | Physical frame number to store |
| wr_valid | input | 1 | Valid bit to store |
| wr_writable | input | 1 | Write-permission bit to store |
| wired_we | input | 1 | Load a new pinned-slot boundary |
| wired_val | input | 6 | New boundary value |
| rnd_index | output | 6 | Current replacement slot |
| res_valid | output | 1 | Result present for the previous cycle's lookup |
| res_hit | output | 1 | Translation succeeded |
| res_miss | output | 1 | No qualifying entry |
| res_prot_fault | output | 1 | Region above the current privilege |
| res_mod_fault | output | 1 | Store to an entry without write permission |
| res_multi_hit | output | 1 | More than one entry qualified |
| res_paddr | output | 36 | Physical address on a hit, zero otherwise |

## Verification
The bench probes entries that agree on page number but differ in tag. A design that ignored the tag would hit where a miss is due. It stores duplicate mappings in two slots: a wrong priority order returns the higher slot's frame, and a missing flag leaves `res_multi_hit` low. It tries each mode against each region, including kernel-only encodings whose bit 30 differs, where a design that decoded only bit 31 or bit 29 would let a lower mode through. It also pins a low range of slots and issues many replacement-slot writes afterwards. A countdown that wrapped one slot late or early, or an unclamped boundary, would overwrite a pinned slot or drift from the reference countdown.

// File: rtl/tlb_asid_pkg.sv
package tlb_asid_pkg;

    localparam int unsigned VA_W   = 32;
    localparam int unsigned OFF_W  = 12;
    localparam int unsigned VPN_W  = VA_W - OFF_W;
    localparam int unsigned PFN_W  = 24;
    localparam int unsigned PA_W   = PFN_W + OFF_W;
    localparam int unsigned ASID_W = 8;

    typedef enum logic [1:0] {
        LVL_USER   = 2'd0,
        LVL_SUPER  = 2'd1,
        LVL_KERNEL = 2'd2
    } priv_lvl_e;

    typedef struct packed {
        logic              valid;
        logic              writable;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PFN_W-1:0]  pfn;
    } tlb_entry_t;

    typedef struct packed {
        logic             valid;
        logic             hit;
        logic             miss;
        logic             prot;
        logic             modf;
        logic             multi;
        logic [PA_W-1:0]  paddr;
    } tlb_result_t;

endpackage

// File: rtl/tlb_priv_gate.sv
module tlb_priv_gate
    import tlb_asid_pkg::*;
(
    input  logic [2:0] region_bits,
    input  logic [1:0] mode,
    output logic       fault
);

    priv_lvl_e need_lvl;
    priv_lvl_e have_lvl;

    always_comb begin
        if (!region_bits[2]) begin
            need_lvl = LVL_USER;
        end else if (region_bits == 3'b110) begin
            need_lvl = LVL_SUPER;
        end else begin
            need_lvl = LVL_KERNEL;
        end

        unique case (mode)
            2'b00:   have_lvl = LVL_USER;
            2'b01:   have_lvl = LVL_SUPER;
            default: have_lvl = LVL_KERNEL;
        endcase

        fault = (need_lvl > have_lvl);
    end

endmodule

// File: rtl/tlb_victim_ctr.sv
module tlb_victim_ctr #(
    parameter int unsigned NUM_ENTRIES = 48,
    parameter int unsigned IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wired_we,
    input  logic [IDX_W-1:0] wired_val,
    output logic [IDX_W-1:0] rnd_idx,
    output logic [IDX_W-1:0] wired_idx
);

    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NUM_ENTRIES - 1);

    typedef struct packed {
        logic [IDX_W-1:0] wired;
        logic [IDX_W-1:0] ctr;
    } vctr_st_t;

    vctr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wired_we) begin
            st_d.wired = (wired_val > TOP_IDX) ? TOP_IDX : wired_val;
            st_d.ctr   = TOP_IDX;
        end else if (st_q.ctr <= st_q.wired) begin
            st_d.ctr = TOP_IDX;
        end else begin
            st_d.ctr = st_q.ctr - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{wired: '0, ctr: TOP_IDX};
        end else begin
            st_q <= st_d;
        end
    end

    assign rnd_idx   = st_q.ctr;
    assign wired_idx = st_q.wired;

    AST_RND_NOT_PINNED: assert property (@(posedge clk) disable iff (!rst_n)
        (rnd_idx >= wired_idx) && (rnd_idx <= TOP_IDX)); // R9

    AST_RND_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!wired_we && (rnd_idx > wired_idx)) |=> (rnd_idx == $past(rnd_idx) - 1'b1)); // R7

    AST_RND_WRAP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (!wired_we && (rnd_idx == wired_idx)) |=> (rnd_idx == TOP_IDX)); // R7

    AST_WIRED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wired_we |=> ((rnd_idx == TOP_IDX) && (wired_idx <= TOP_IDX))); // R8

endmodule

// File: rtl/tlb_entry_cam.sv
module tlb_entry_cam
    import tlb_asid_pkg::*;
#(
    parameter int unsigned NUM_ENTRIES = 48,
    parameter int unsigned IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  tlb_entry_t        wr_entry,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              match_any,
    output logic              match_multi,
    output tlb_entry_t        match_entry
);

    typedef struct packed {
        tlb_entry_t [NUM_ENTRIES-1:0] ent;
    } cam_st_t;

    cam_st_t st_d, st_q;
    logic [NUM_ENTRIES-1:0] hit_vec;
    logic [IDX_W-1:0]       sel_idx;
    logic                   wr_in_range;

    assign wr_in_range = (32'(wr_idx) < NUM_ENTRIES);

    always_comb begin
        st_d = st_q;
        if (wr_en && wr_in_range) begin
            st_d.ent[wr_idx] = wr_entry;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_match
        assign hit_vec[g] = st_q.ent[g].valid
                          && (st_q.ent[g].vpn  == lk_vpn)
                          && (st_q.ent[g].asid == lk_asid);
    end

    always_comb begin
        sel_idx = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                sel_idx = IDX_W'(i);
            end
        end
    end

    assign match_any   = |hit_vec;
    assign match_multi = ($countones(hit_vec) > 1);
    assign match_entry = st_q.ent[sel_idx];

    AST_MULTI_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        match_multi |-> match_any); // R5

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_in_range) |=> (st_q.ent[$past(wr_idx)] == $past(wr_entry))); // R6

endmodule

// File: rtl/tlb_asid_top.sv
module tlb_asid_top
    import tlb_asid_pkg::*;
#(
    parameter int unsigned NUM_ENTRIES = 48,
    parameter int unsigned IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [31:0]       lk_vaddr,
    input  logic [7:0]        lk_asid,
    input  logic [1:0]        lk_mode,
    input  logic              lk_store,
    input  logic              wr_en,
    input  logic              wr_random,
    input  logic [IDX_W-1:0]  wr_index,
    input  logic [19:0]       wr_vpn,
    input  logic [7:0]        wr_asid,
    input  logic [23:0]       wr_pfn,
    input  logic              wr_valid,
    input  logic              wr_writable,
    input  logic              wired_we,
    input  logic [IDX_W-1:0]  wired_val,
    output logic [IDX_W-1:0]  rnd_index,
    output logic              res_valid,
    output logic              res_hit,
    output logic              res_miss,
    output logic              res_prot_fault,
    output logic              res_mod_fault,
    output logic              res_multi_hit,
    output logic [35:0]       res_paddr
);

    logic [IDX_W-1:0] rnd_idx;
    logic [IDX_W-1:0] wired_idx;
    logic [IDX_W-1:0] slot_sel;
    logic             priv_fault;
    logic             cam_any;
    logic             cam_multi;
    tlb_entry_t       cam_entry;
    tlb_entry_t       new_entry;
    tlb_result_t      res_d, res_q;

    tlb_victim_ctr #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .IDX_W       (IDX_W)
    ) u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .wired_we  (wired_we),
        .wired_val (wired_val),
        .rnd_idx   (rnd_idx),
        .wired_idx (wired_idx)
    );

    assign slot_sel  = wr_random ? rnd_idx : wr_index;
    assign new_entry = '{valid: wr_valid, writable: wr_writable, asid: wr_asid,
                         vpn: wr_vpn, pfn: wr_pfn};

    tlb_entry_cam #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .IDX_W       (IDX_W)
    ) u_cam (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_idx      (slot_sel),
        .wr_entry    (new_entry),
        .lk_vpn      (lk_vaddr[VA_W-1:OFF_W]),
        .lk_asid     (lk_asid),
        .match_any   (cam_any),
        .match_multi (cam_multi),
        .match_entry (cam_entry)
    );

    tlb_priv_gate u_priv (
        .region_bits (lk_vaddr[31:29]),
        .mode        (lk_mode),
        .fault       (priv_fault)
    );

    always_comb begin
        res_d = '0;
        if (lk_valid) begin
            res_d.valid = 1'b1;
            if (priv_fault) begin
                res_d.prot = 1'b1;
            end else if (!cam_any) begin
                res_d.miss = 1'b1;
            end else begin
                res_d.multi = cam_multi;
                if (lk_store && !cam_entry.writable) begin
                    res_d.modf = 1'b1;
                end else begin
                    res_d.hit   = 1'b1;
                    res_d.paddr = {cam_entry.pfn, lk_vaddr[OFF_W-1:0]};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign rnd_index      = rnd_idx;
    assign res_valid      = res_q.valid;
    assign res_hit        = res_q.hit;
    assign res_miss       = res_q.miss;
    assign res_prot_fault = res_q.prot;
    assign res_mod_fault  = res_q.modf;
    assign res_multi_hit  = res_q.multi;
    assign res_paddr      = res_q.paddr;

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ($countones({res_hit, res_miss, res_prot_fault, res_mod_fault}) == 1)); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> ({res_hit, res_miss, res_prot_fault, res_mod_fault, res_multi_hit} == '0
                        && res_paddr == '0)); // R11

    AST_USER_HIGH_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_mode == 2'b00 && lk_vaddr[31]) |=> res_prot_fault); // R3

    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (!res_hit || res_paddr[11:0] == $past(lk_vaddr[11:0]))); // R1

    AST_PROT_NO_MULTI: assert property (@(posedge clk) disable iff (!rst_n)
        res_prot_fault |-> (!res_multi_hit && res_paddr == '0)); // R5

endmodule

// File: tb/tlb_asid_top_test.sv
module tlb_asid_top_test;
    import tlb_asid_pkg::*;

    localparam int NE = 48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [7:0]  lk_asid = '0;
    logic [1:0]  lk_mode = '0;
    logic        lk_store = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_random = 1'b0;
    logic [5:0]  wr_index = '0;
    logic [19:0] wr_vpn = '0;
    logic [7:0]  wr_asid = '0;
    logic [23:0] wr_pfn = '0;
    logic        wr_valid = 1'b0;
    logic        wr_writable = 1'b0;
    logic        wired_we = 1'b0;
    logic [5:0]  wired_val = '0;
    logic [5:0]  rnd_index;
    logic        res_valid, res_hit, res_miss, res_prot_fault, res_mod_fault, res_multi_hit;
    logic [35:0] res_paddr;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    tlb_asid_top uut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_asid(lk_asid), .lk_mode(lk_mode), .lk_store(lk_store),
        .wr_en(wr_en), .wr_random(wr_random), .wr_index(wr_index), .wr_vpn(wr_vpn),
        .wr_asid(wr_asid), .wr_pfn(wr_pfn), .wr_valid(wr_valid), .wr_writable(wr_writable),
        .wired_we(wired_we), .wired_val(wired_val), .rnd_index(rnd_index),
        .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss),
        .res_prot_fault(res_prot_fault), .res_mod_fault(res_mod_fault),
        .res_multi_hit(res_multi_hit), .res_paddr(res_paddr)
    );

    // Reference model of table contents and replacement countdown
    tlb_entry_t m_tab [NE];
    int m_ctr;
    int m_wired;
    int m_slot;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NE; i++) m_tab[i] <= '0;
            m_ctr   <= NE - 1;
            m_wired <= 0;
        end else begin
            if (wired_we) begin
                m_wired <= (int'(wired_val) > NE - 1) ? NE - 1 : int'(wired_val);
                m_ctr   <= NE - 1;
            end else begin
                m_ctr <= (m_ctr <= m_wired) ? NE - 1 : m_ctr - 1;
            end
            if (wr_en) begin
                m_slot = wr_random ? m_ctr : int'(wr_index);
                if (m_slot < NE)
                    m_tab[m_slot] <= '{valid: wr_valid, writable: wr_writable,
                                       asid: wr_asid, vpn: wr_vpn, pfn: wr_pfn};
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // {hit, miss, prot, mod, multi, paddr}
    function automatic logic [40:0] exp_lookup(input logic [31:0] va, input logic [7:0] asid,
                                                input logic [1:0] mode, input bit store);
        int need, have, first, cnt;
        logic [40:0] r;
        r = '0;
        need = !va[31] ? 0 : (va[31:29] == 3'b110) ? 1 : 2;
        have = (mode == 2'b00) ? 0 : (mode == 2'b01) ? 1 : 2;
        if (need > have) begin
            r[38] = 1'b1;
            return r;
        end
        first = -1;
        cnt = 0;
        for (int i = 0; i < NE; i++) begin
            if (m_tab[i].valid && m_tab[i].vpn == va[31:12] && m_tab[i].asid == asid) begin
                cnt++;
                if (first < 0) first = i;
            end
        end
        if (cnt == 0) begin
            r[39] = 1'b1;
            return r;
        end
        r[36] = (cnt > 1);
        if (store && !m_tab[first].writable) begin
            r[37] = 1'b1;
        end else begin
            r[40] = 1'b1;
            r[35:0] = {m_tab[first].pfn, va[11:0]};
        end
        return r;
    endfunction

    task automatic do_lookup(input logic [31:0] va, input logic [7:0] asid,
                             input logic [1:0] mode, input bit store, input string tag);
        logic [40:0] exp, act;
        lk_vaddr = va; lk_asid = asid; lk_mode = mode; lk_store = store; lk_valid = 1'b1;
        exp = exp_lookup(va, asid, mode, store);
        @(posedge clk);
        @(negedge clk);
        lk_valid = 1'b0;
        act = {res_hit, res_miss, res_prot_fault, res_mod_fault, res_multi_hit, res_paddr};
        check(res_valid && act == exp, tag, {22'd0, res_valid, act}, {22'd0, 1'b1, exp});
    endtask

    task automatic do_write(input bit rnd, input logic [5:0] idx, input logic [19:0] vpn,
                            input logic [7:0] asid, input logic [23:0] pfn,
                            input bit v, input bit w);
        wr_random = rnd; wr_index = idx; wr_vpn = vpn; wr_asid = asid; wr_pfn = pfn;
        wr_valid = v; wr_writable = w; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_wired(input logic [5:0] val);
        wired_val = val; wired_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wired_we = 1'b0;
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [19:0] vpn;
        logic [31:0] va;
        void'($urandom(32'd20051));
        repeat (2) @(negedge clk);
        // R10: reset state
        check({res_valid, res_hit, res_miss, res_prot_fault, res_mod_fault, res_multi_hit} == '0
              && res_paddr == '0, "R10 reset outputs", {22'd0, res_valid, res_paddr}, 64'd0);
        check(rnd_index == 6'd47, "R7 reset countdown", 64'(rnd_index), 64'd47);
        rst_n = 1'b1;
        @(negedge clk);
        do_lookup(32'h0001_2345, 8'd0, 2'b10, 1'b0, "R10 empty table misses");

        // R7: countdown follows model
        repeat (5) begin
            @(negedge clk);
            check(int'(rnd_index) == m_ctr, "R7 countdown step", 64'(rnd_index), 64'(m_ctr));
        end
        repeat (60) @(negedge clk);
        check(int'(rnd_index) == m_ctr, "R7 countdown wrap", 64'(rnd_index), 64'(m_ctr));

        // R1/R2: basic hit, tag mismatch, invalid entry
        do_write(1'b0, 6'd5, 20'h0_0ABC, 8'd3, 24'h12_3456, 1'b1, 1'b1);
        do_lookup(32'h00AB_C7F1, 8'd3, 2'b00, 1'b0, "R1 user hit paddr");
        do_lookup(32'h00AB_C000, 8'd4, 2'b10, 1'b0, "R2 tag mismatch miss");
        do_write(1'b0, 6'd6, 20'h0_0DEF, 8'd3, 24'h00_0077, 1'b0, 1'b1);
        do_lookup(32'h00DE_F010, 8'd3, 2'b10, 1'b0, "R2 invalid entry miss");

        // R3: region checks
        do_write(1'b0, 6'd7, 20'hC_0001, 8'd3, 24'hAA_0001, 1'b1, 1'b1);
        do_write(1'b0, 6'd8, 20'hA_0002, 8'd3, 24'hAA_0002, 1'b1, 1'b1);
        do_write(1'b0, 6'd9, 20'hE_0003, 8'd3, 24'hAA_0003, 1'b1, 1'b1);
        do_lookup(32'hC000_1004, 8'd3, 2'b00, 1'b0, "R3 user to supervisor region");
        do_lookup(32'hC000_1004, 8'd3, 2'b01, 1'b0, "R3 supervisor own region");
        do_lookup(32'hA000_2008, 8'd3, 2'b01, 1'b0, "R3 supervisor to kernel region");
        do_lookup(32'hE000_300C, 8'd3, 2'b01, 1'b0, "R3 supervisor to kernel 111");
        do_lookup(32'hE000_300C, 8'd3, 2'b11, 1'b0, "R3 kernel mode 11");
        do_lookup(32'h8000_0000, 8'd3, 2'b00, 1'b0, "R3 user to kernel unmapped");

        // R4: write permission
        do_write(1'b0, 6'd11, 20'h0_1111, 8'd3, 24'h00_BEEF, 1'b1, 1'b0);
        do_lookup(32'h0111_1ABC, 8'd3, 2'b00, 1'b1, "R4 store to read-only");
        do_lookup(32'h0111_1ABC, 8'd3, 2'b00, 1'b0, "R4 load from read-only");
        do_lookup(32'h00AB_C123, 8'd3, 2'b00, 1'b1, "R4 store to writable");

        // R5: duplicates, lowest slot wins
        do_write(1'b0, 6'd30, 20'h0_2222, 8'd9, 24'h00_0030, 1'b1, 1'b1);
        do_write(1'b0, 6'd12, 20'h0_2222, 8'd9, 24'h00_0012, 1'b1, 1'b0);
        do_lookup(32'h0222_2555, 8'd9, 2'b00, 1'b0, "R5 multi lowest slot");
        do_lookup(32'h0222_2555, 8'd9, 2'b00, 1'b1, "R5 multi with modify fault");
        do_lookup(32'hA222_2555, 8'd9, 2'b00, 1'b0, "R5 no multi on prot fault");

        // R6: out-of-range explicit index writes nothing
        do_write(1'b0, 6'd50, 20'h0_3333, 8'd3, 24'h00_0050, 1'b1, 1'b1);
        do_lookup(32'h0333_3000, 8'd3, 2'b00, 1'b0, "R6 index 50 ignored");
        do_write(1'b0, 6'd47, 20'h0_3333, 8'd3, 24'h00_0047, 1'b1, 1'b1);
        do_lookup(32'h0333_3000, 8'd3, 2'b00, 1'b0, "R6 top slot write");

        // R11: idle result
        @(negedge clk);
        check({res_valid, res_hit, res_miss, res_prot_fault, res_mod_fault, res_multi_hit} == '0
              && res_paddr == '0, "R11 idle outputs", {22'd0, res_valid, res_paddr}, 64'd0);

        // R8: boundary clamp and reload
        set_wired(6'd60);
        check(rnd_index == 6'd47, "R8 clamp reload", 64'(rnd_index), 64'd47);
        repeat (3) @(negedge clk);
        check(rnd_index == 6'd47, "R8 clamped stays at top", 64'(rnd_index), 64'd47);
        set_wired(6'd20);
        check(rnd_index == 6'd47, "R8 reload top", 64'(rnd_index), 64'd47);

        // R9: pin slots 0..19, then many replacement writes
        for (int i = 0; i < 20; i++)
            do_write(1'b0, 6'(i), 20'h4_0000 + 20'(i), 8'd5, 24'h40_0000 + 24'(i), 1'b1, 1'b1);
        for (int i = 0; i < 80; i++) begin
            check(int'(rnd_index) == m_ctr, "R9 slot tracks countdown", 64'(rnd_index), 64'(m_ctr));
            do_write(1'b1, 6'd0, 20'h5_0000 + 20'(i), 8'd5, 24'h50_0000 + 24'(i), 1'b1, 1'b1);
        end
        for (int i = 0; i < 20; i += 4)
            do_lookup({12'h400, 8'(i), 12'h0F0}, 8'd5, 2'b10, 1'b0, "R9 pinned slot kept");
        do_lookup({20'h5_004F, 12'h001}, 8'd5, 2'b10, 1'b0, "R9 latest random write");

        // Constrained random mix
        for (int it = 0; it < 400; it++) begin
            logic [2:0] rg;
            int sel;
            sel = $urandom_range(4, 0);
            rg  = (sel == 0) ? 3'b000 : (sel == 1) ? 3'b011 : (sel == 2) ? 3'b110 :
                  (sel == 3) ? 3'b100 : 3'b111;
            vpn = {rg, 17'($urandom_range(5, 0))};
            if ($urandom_range(2, 0) == 0) begin
                do_write(1'($urandom_range(1, 0)), 6'($urandom_range(51, 0)), vpn,
                         8'($urandom_range(2, 1)), 24'($urandom), 1'($urandom_range(7, 0) != 0),
                         1'($urandom_range(1, 0)));
            end else begin
                va = {vpn, 12'($urandom)};
                do_lookup(va, 8'($urandom_range(2, 1)), 2'($urandom_range(3, 0)),
                          1'($urandom_range(1, 0)), "R1 R2 R3 R4 R5 random lookup");
            end
        end
        finish_run();
    end

endmodule